// File: doc/BRIEF.md
# Indirect Coefficient Memory Access Port

This block lets a host processor reach a 768-word coefficient store through just two registers on a small synchronous register bus. One register is a location pointer. The other is a data window. Every read or write of the window reaches the word the pointer currently selects. After the access, the pointer steps forward by one.

Filling a contiguous block takes one pointer write followed by a burst of window accesses. Reaching scattered locations takes a fresh pointer write before each access. The word width is a parameter. The store is inferred as internal storage.

Each bus cycle is one access, qualified by `sel`. `reg_sel` picks the register: 0 selects the pointer and 1 selects the data window. `wr_en` picks between a write and a read. Read results appear on `rdata` one clock after the access and stay there until the next read.

Top module: `coef_port`

## Requirements
- R1: After reset the pointer is 0, and the pointer never holds a value above 767.
- R2: A write with `reg_sel`=1 stores `wdata` at the word the pointer selects. The pointer then advances by one.
- R3: A read with `reg_sel`=1 places the word at the pointer on `rdata` on the clock edge that follows the access. The pointer then advances by one, so a burst of reads returns consecutive words.
- R4: When the pointer is at 767, a data-window access leaves it at 0.
- R5: A write with `reg_sel`=0 replaces the pointer, so the next window access goes to that location. Any value above 767 is stored as 767.
- R6: A read with `reg_sel`=0 places the pointer, zero-extended, on `rdata` one clock later, and leaves the pointer unchanged.
- R7: While `sel` is low, the pointer, the stored words and `rdata` keep their values, whatever `wr_en`, `reg_sel` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Qualifies a register access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = pointer register, 1 = data window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid from the clock after a read |

## Verification
A pointer that goes wrong inside the block does not always show up on a write. It shows up on the next pointer read, one clock later. It also shows up on any read-back of the data window, which returns a word from the wrong location. Skipping, repeating or wrapping the pointer too early shifts every later word of a burst by one place. A write that lands at the wrong address stays hidden until that location is read back. For that reason the bench reads back every location it writes, including the locations around the wrap and clamp boundaries.

// File: rtl/coef_port.sv
module coef_port #(
  parameter int DEPTH  = 768,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int          AW   = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     ptr;

  wire win_acc = sel && reg_sel;
  wire win_wr  = win_acc && wr_en;
  wire win_rd  = win_acc && !wr_en;
  wire ptr_wr  = sel && !reg_sel && wr_en;
  wire ptr_rd  = sel && !reg_sel && !wr_en;

  wire [AW-1:0] ptr_next = (ptr == LAST) ? '0 : ptr + AW'(1);
  wire [AW-1:0] ptr_load = (wdata > DATA_W'(LAST)) ? LAST : wdata[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (ptr_wr)  ptr <= ptr_load;
    else if (win_acc) ptr <= ptr_next;
  end

  always_ff @(posedge clk)
    if (win_wr) mem[ptr] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (win_rd) rdata <= mem[ptr];
    else if (ptr_rd) rdata <= DATA_W'(ptr);
  end

  a_r1_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && ptr != LAST) |=> ptr == $past(ptr) + AW'(1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && ptr == LAST) |=> ptr == '0);

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && wdata <= DATA_W'(LAST)) |=> DATA_W'(ptr) == $past(wdata));

  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && wdata > DATA_W'(LAST)) |=> ptr == LAST);

  a_r6_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd |=> ($stable(ptr) && rdata == DATA_W'($past(ptr))));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(ptr) && $stable(rdata)));
endmodule

// File: tb/coef_port_bench.sv
module coef_port_bench;
  localparam int DEPTH  = 768;
  localparam int DATA_W = 16;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              sel = 0, wr_en = 0, reg_sel = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;

  int total = 0, bad = 0;
  int m_ptr = 0;
  logic [DATA_W-1:0] m_mem [DEPTH];
  logic [DATA_W-1:0] exp_q [$];
  string             tag_q [$];
  logic [DATA_W-1:0] last_rd = '0;

  always #5 clk = ~clk;

  coef_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_coef_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata));

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic rs, input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    sel = 1; wr_en = wr; reg_sel = rs; wdata = d;
    if (!rs && wr) m_ptr = (d > DEPTH - 1) ? DEPTH - 1 : int'(d);
    else if (!rs) begin exp_q.push_back(DATA_W'(m_ptr)); tag_q.push_back(tag); end
    else begin
      if (wr) m_mem[m_ptr] = d;
      else begin exp_q.push_back(m_mem[m_ptr]); tag_q.push_back(tag); end
      m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    sel = 0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    automatic logic was_rd = rst_n && sel && !wr_en;
    #1;
    if (was_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", rdata, rdata ^ 1'b1);
      else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
        last_rd = e;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata after reset", rdata, '0);
    acc(0, 0, 0, "R1 pointer after reset");

    acc(1, 0, 0, "");
    acc(1, 1, 16'h111, ""); acc(1, 1, 16'h456, ""); acc(1, 1, 16'h321, "");
    acc(0, 0, 0, "R2 pointer after three writes");
    acc(1, 0, 0, "");
    acc(0, 1, 0, "R3 burst read word 0");
    acc(0, 1, 0, "R3 burst read word 1");
    acc(0, 1, 0, "R3 burst read word 2");
    acc(0, 0, 0, "R3 pointer after reads");

    acc(1, 0, 10, ""); acc(1, 1, 16'haaaa, "");
    acc(1, 0, 12, ""); acc(1, 1, 16'hcccc, "");
    acc(1, 0, 11, ""); acc(1, 1, 16'hbbbb, "");
    acc(0, 0, 0, "R5 pointer after scattered writes");
    acc(1, 0, 10, "");
    for (int i = 0; i < 3; i++) acc(0, 1, 0, "R5 scattered read-back");

    acc(1, 0, 100, "");
    for (int i = 0; i < 20; i++) acc(1, 1, DATA_W'(16'h5a00 + i * 7), "");
    acc(1, 0, 100, "");
    for (int i = 0; i < 20; i++) acc(0, 1, 0, "R2 R3 burst of twenty");

    acc(1, 0, 766, ""); acc(1, 1, 16'h7661, ""); acc(1, 1, 16'h7671, "");
    acc(0, 0, 0, "R4 pointer wrapped after write");
    acc(1, 1, 16'h0f0f, "");
    acc(1, 0, 766, "");
    acc(0, 1, 0, "R4 read 766"); acc(0, 1, 0, "R4 read 767");
    acc(0, 1, 0, "R4 read wrapped to 0");

    acc(1, 0, 1000, ""); acc(0, 0, 0, "R5 clamp 1000 to 767");
    acc(1, 0, 16'hffff, ""); acc(0, 0, 0, "R5 clamp all-ones");
    acc(1, 0, 767, ""); acc(0, 0, 0, "R5 exact 767");
    acc(0, 0, 0, "R6 pointer read repeated");

    acc(1, 0, 11, ""); acc(0, 0, 0, "R6 pointer before idle");
    @(negedge clk);
    sel = 0; wr_en = 1; reg_sel = 1; wdata = 16'hdead;
    @(negedge clk); reg_sel = 0; wdata = 16'h0003;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    check("R7 rdata held while idle", rdata, last_rd);
    acc(0, 0, 0, "R7 pointer unchanged by idle bus");
    acc(0, 1, 0, "R7 word unchanged by idle bus");
    idle(3);

    if (exp_q.size() != 0) check("scoreboard drained", DATA_W'(exp_q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule